// File: doc/BRIEF.md
# ROMix Mixing Controller

This block sequences the memory-hard mixing stage of a password-style key derivation. It works on a 1024-bit state with cost N = 1024 and block factor r = 1. A start pulse loads the input state. In the fill phase, N steps each store the current state into an internal scratchpad at the step's index. Each step then replaces the state with the result of one BlockMix operation.

In the lookup phase, N steps each pick a stored word using a bit slice of the current state. The step XORs that word into the state and sends the sum through BlockMix again. After the last lookup step, the final state appears on the output and a one-cycle done pulse marks it.

BlockMix itself is computed outside the block. The block talks to it through a request channel and a response channel, both valid/ready:
- A request is offered with `mix_req_valid`. It stays up with unchanged data until `mix_req_ready` is seen at a clock edge, so the BlockMix unit may stall it for any number of cycles.
- The block raises `mix_rsp_ready` only while it waits for the answer to its single outstanding request. A response offered at any other time is simply not taken.

The scratchpad is a single-port RAM with one cycle of read latency. Start, busy and done are plain control pins.

Top module: `romix_ctrl`

## Requirements
- R1: After reset, `done`, `busy`, `mix_req_valid` and `mix_rsp_ready` are all low, and they stay low while the block is idle.
- R2: A `start` sampled high while idle captures `din` as the state, and `busy` is high from the next cycle until the run completes.
- R3: Fill step k (k = 0..N-1) issues request k carrying the state before that step. Request 0 therefore carries `din`, and request k+1 carries the response to request k. Before issuing request k, the state is written to scratchpad word k.
- R4: Each lookup step takes its scratchpad index from state bits [IDX_LSB + log2(N) - 1 : IDX_LSB]. With the defaults this is bits [489:480], read as an unsigned number.
- R5: Each lookup request carries the current state XOR the scratchpad word selected by R4. The response becomes the new state.
- R6: A run issues exactly 2N requests, and at most one is outstanding. `mix_req_valid` is never high while `mix_rsp_ready` is high.
- R7: Once raised, `mix_req_valid` stays high with `mix_req_data` unchanged until the cycle in which `mix_req_ready` is high.
- R8: The response to the last lookup request appears on `dout` in the cycle `done` is high. `done` is high for exactly one cycle, and `dout` does not change in any other cycle.
- R9: A `start` received while `busy` is high has no effect on the run, its requests or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run with `din` (honoured only while idle) |
| din | input | STATE_W | Input state |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: `dout` holds a new result |
| dout | output | STATE_W | Result state, held until the next result |
| mix_req_valid | output | 1 | BlockMix request offered |
| mix_req_ready | input | 1 | BlockMix unit accepts the request |
| mix_req_data | output | STATE_W | State to be mixed |
| mix_rsp_valid | input | 1 | BlockMix result offered |
| mix_rsp_ready | output | 1 | Block waits for a BlockMix result |
| mix_rsp_data | input | STATE_W | Mixed state |

## Verification
The bench stands in for BlockMix with a simple invertible scramble. Every request is compared against a queue produced by a behavioural model of the two phases.

An all-zero input with an always-ready BlockMix side checks the basic fill order and lookup indices without stalls. A dense bit pattern with irregular request stalls and response delays separates correct request holding from a controller that drops or changes a stalled request. A third pattern also pulses `start` during the run, with different data. That run checks that the busy controller ignores the pulse: the request stream and the result must still match the first input.

// File: rtl/romix_pkg.sv
package romix_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FILL_WR,
    PH_FILL_MIX,
    PH_LOOK_RD,
    PH_LOOK_MIX,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/romix_scratchpad.sv
module romix_scratchpad #(
  parameter int WORDS  = 1024,
  parameter int WIDTH  = 1024,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  // single port: a write cycle leaves the read register untouched
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/romix_seq.sv
module romix_seq
  import romix_pkg::*;
#(
  parameter int COST_N = 1024,
  parameter int IDX_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_fire,
  input  logic             rsp_fire,
  output phase_e           phase,
  output logic [IDX_W-1:0] iter,
  output logic             last,
  output logic             req_sent
);
  localparam logic [IDX_W-1:0] LastIter = IDX_W'(COST_N - 1);

  assign last = (iter == LastIter);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      iter     <= '0;
      req_sent <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_FILL_WR;
            iter  <= '0;
          end
        end
        PH_FILL_WR: begin
          phase    <= PH_FILL_MIX;
          req_sent <= 1'b0;
        end
        PH_LOOK_RD: begin
          phase    <= PH_LOOK_MIX;
          req_sent <= 1'b0;
        end
        PH_FILL_MIX, PH_LOOK_MIX: begin
          if (req_fire) req_sent <= 1'b1;
          if (rsp_fire) begin
            req_sent <= 1'b0;
            if (last) begin
              iter  <= '0;
              phase <= (phase == PH_FILL_MIX) ? PH_LOOK_RD : PH_DONE;
            end else begin
              iter  <= iter + 1'b1;
              phase <= (phase == PH_FILL_MIX) ? PH_FILL_WR : PH_LOOK_RD;
            end
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/romix_ctrl.sv
module romix_ctrl
  import romix_pkg::*;
#(
  parameter int STATE_W = 1024,
  parameter int COST_N  = 1024,
  parameter int IDX_LSB = 480
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [STATE_W-1:0] din,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] dout,
  output logic               mix_req_valid,
  input  logic               mix_req_ready,
  output logic [STATE_W-1:0] mix_req_data,
  input  logic               mix_rsp_valid,
  output logic               mix_rsp_ready,
  input  logic [STATE_W-1:0] mix_rsp_data
);
  localparam int IDX_W = $clog2(COST_N);

  phase_e             phase;
  logic [IDX_W-1:0]   iter;
  logic               last;
  logic               req_sent;
  logic               req_fire;
  logic               rsp_fire;
  logic               mixing;
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] rd_word;
  logic [IDX_W-1:0]   look_idx;
  logic               ram_en;
  logic               ram_we;
  logic [IDX_W-1:0]   ram_addr;

  romix_seq #(.COST_N(COST_N), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .req_fire (req_fire),
    .rsp_fire (rsp_fire),
    .phase    (phase),
    .iter     (iter),
    .last     (last),
    .req_sent (req_sent)
  );

  assign look_idx = state_q[IDX_LSB +: IDX_W];
  assign ram_en   = (phase == PH_FILL_WR) || (phase == PH_LOOK_RD);
  assign ram_we   = (phase == PH_FILL_WR);
  assign ram_addr = ram_we ? iter : look_idx;

  romix_scratchpad #(.WORDS(COST_N), .WIDTH(STATE_W), .ADDR_W(IDX_W)) u_pad (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (state_q),
    .rdata (rd_word)
  );

  assign mixing        = (phase == PH_FILL_MIX) || (phase == PH_LOOK_MIX);
  assign mix_req_valid = mixing && !req_sent;
  assign mix_rsp_ready = mixing && req_sent;
  assign req_fire      = mix_req_valid && mix_req_ready;
  assign rsp_fire      = mix_rsp_valid && mix_rsp_ready;
  assign mix_req_data  = (phase == PH_LOOK_MIX) ? (state_q ^ rd_word) : state_q;
  assign busy          = (phase != PH_IDLE);
  assign done          = (phase == PH_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (phase == PH_IDLE && start) begin
      state_q <= din;
    end else if (rsp_fire) begin
      state_q <= mix_rsp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (rsp_fire && phase == PH_LOOK_MIX && last) begin
      dout <= mix_rsp_data;
    end
  end
endmodule

// File: rtl/romix_ctrl_chk.sv
module romix_ctrl_chk #(
  parameter int STATE_W = 1024
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [STATE_W-1:0] dout,
  input logic               mix_req_valid,
  input logic               mix_req_ready,
  input logic [STATE_W-1:0] mix_req_data,
  input logic               mix_rsp_ready
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mix_req_valid && !mix_rsp_ready && !done)); // R1

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mix_rsp_ready |-> !mix_req_valid); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_req_valid && !mix_req_ready) |=> (mix_req_valid && $stable(mix_req_data))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dout)); // R8
endmodule

bind romix_ctrl romix_ctrl_chk #(.STATE_W(STATE_W)) u_chk (.*);

// File: tb/test_romix_ctrl.sv
module test_romix_ctrl;
  localparam int W   = 1024;
  localparam int N   = 8;
  localparam int LSB = 480;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] din = '0;
  logic         busy, done;
  logic [W-1:0] dout;
  logic         mix_req_valid;
  logic         mix_req_ready = 1'b0;
  logic [W-1:0] mix_req_data;
  logic         mix_rsp_valid = 1'b0;
  logic         mix_rsp_ready;
  logic [W-1:0] mix_rsp_data = '0;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  int stall_mode = 0;
  int nreq = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] exp_out;

  always #10 clk = ~clk;

  romix_ctrl #(.STATE_W(W), .COST_N(N), .IDX_LSB(LSB)) i_romix_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .busy(busy), .done(done), .dout(dout),
    .mix_req_valid(mix_req_valid), .mix_req_ready(mix_req_ready),
    .mix_req_data(mix_req_data),
    .mix_rsp_valid(mix_rsp_valid), .mix_rsp_ready(mix_rsp_ready),
    .mix_rsp_data(mix_rsp_data)
  );

  function automatic logic [W-1:0] bm(input logic [W-1:0] x);
    return ({x[W-14:0], x[W-1:W-13]} ^ {32{32'h9E3779B9}}) + W'(1234567);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model: fills the expected request queue and result
  task automatic build_model(input logic [W-1:0] x0);
    logic [W-1:0] pad [N];
    logic [W-1:0] s;
    s = x0;
    exp_q.delete();
    for (int i = 0; i < N; i++) begin
      pad[i] = s;
      exp_q.push_back(s);
      s = bm(s);
    end
    for (int j = 0; j < N; j++) begin
      int k;
      logic [W-1:0] r;
      k = int'(s[LSB +: $clog2(N)]);
      r = s ^ pad[k];
      exp_q.push_back(r);
      s = bm(r);
    end
    exp_out = s;
  endtask

  // BlockMix stand-in with optional stalls
  initial begin
    int st = 0;
    int cyc = 0;
    int dly = 0;
    logic [W-1:0] cap = '0;
    forever begin
      @(negedge clk);
      cyc++;
      case (st)
        0: begin
          if (mix_req_valid && (stall_mode == 0 || (cyc % 3) == 0)) begin
            mix_req_ready = 1'b1;
            cap = mix_req_data;
            st = 1;
          end else begin
            mix_req_ready = 1'b0;
          end
        end
        1: begin
          mix_req_ready = 1'b0;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 extra request", cap, '0);
          end else if (nreq < N) begin
            chk(cap == exp_q[0], "R3 fill request", cap, exp_q[0]);
            void'(exp_q.pop_front());
          end else begin
            chk(cap == exp_q[0], "R4/R5 lookup request", cap, exp_q[0]);
            void'(exp_q.pop_front());
          end
          nreq++;
          dly = (stall_mode != 0) ? int'(cap[1:0]) : 0;
          st = 2;
        end
        2: begin
          if (dly == 0) begin
            mix_rsp_valid = 1'b1;
            mix_rsp_data = bm(cap);
            st = 3;
          end else begin
            dly--;
          end
        end
        default: begin
          mix_rsp_valid = 1'b0;
          st = 0;
        end
      endcase
    end
  end

  task automatic run_case(input logic [W-1:0] x0, input int mode, input bit poke);
    int guard;
    build_model(x0);
    nreq = 0;
    stall_mode = mode;
    @(negedge clk);
    din = x0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    din = ~x0;
    chk(busy == 1'b1, "R2 busy after start", W'(busy), W'(1));
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;   // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, "R8 done seen", W'(done), W'(1));
    chk(dout == exp_out, poke ? "R9 result unaffected" : "R8 result", dout, exp_out);
    chk(nreq == 2 * N && exp_q.size() == 0, "R6 request count", W'(nreq), W'(2 * N));
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", W'(done), W'(0));
    repeat (3) @(negedge clk);
    chk(dout == exp_out && !busy, "R8 dout held", dout, exp_out);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !mix_req_valid && !mix_rsp_ready, "R1 reset state",
        W'({done, busy, mix_req_valid, mix_rsp_ready}), '0);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !mix_req_valid, "R1 idle quiet", W'({busy, mix_req_valid}), '0);
    run_case('0, 0, 1'b0);
    run_case({16{64'hF0E1_D2C3_B4A5_9687}}, 1, 1'b0);
    run_case({32{32'h0123_4567}} ^ (W'(1) << LSB), 1, 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule